// File: doc/BRIEF.md
# Low-Power Lane Escape Sequence Receiver

This block watches the two single-ended low-power line levels of one serial data lane, delivered as an already synchronised two-bit value. Bit 1 of that value is the positive line and bit 0 is the negative line, so `2'b10` is LP-10. The receiver acts only when the line state changes. It does not care how long a state is held, except during wake-up. From the stop state (LP-11) it recognises three requests. The first is a high-speed entry. The second is a bus turnaround. The third is an escape entry, after which it decodes spaced-one-hot symbols.

In escape mode the first eight decoded bits form a command byte. One command code leads to low-power data reception, where every further eight bits deliver a byte. Another code leads to the ultra-low-power state, which is left through a timed wake-up. Any other code is reported and then ignored until escape exit. Any malformed sequence raises a one-cycle error pulse. The receiver then stays idle until the lines return to LP-11.

All outputs are registered. A pulse appears in the clock cycle after the first rising edge that samples the line state completing the event.

Top module: `lpesc_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every pulse output is 0. The receiver then becomes ready to accept requests once it has sampled LP-11.
- R2: The sequence LP-11, LP-01, LP-00 gives one `hs_start` pulse in the cycle after LP-00 is first sampled. After that, line changes have no effect until LP-11 is sampled, which returns the receiver to the stop state.
- R3: The sequence LP-11, LP-10, LP-00, LP-10, LP-00 gives one `bta_seen` pulse. After it, line changes have no effect until LP-11 is sampled.
- R4: The sequence LP-11, LP-10, LP-00, LP-01, LP-00 gives one `esc_start` pulse and enters escape mode.
- R5: In escape mode, a Mark is LP-01 (bit 0) or LP-10 (bit 1). The bit is committed when the following Space (LP-00) is seen. The first 8 bits, least significant first, are presented on `cmd_byte` together with a `cmd_vld` pulse.
- R6: The command 8'hE1 selects data reception. Each further group of 8 bits produces one `lpd_vld` pulse with the byte, least significant bit first, on `lpd_byte`.
- R7: The command 8'h1E gives one `ulps_start` pulse, in the same cycle as `cmd_vld`, and enters the ultra-low-power state.
- R8: In the ultra-low-power state, LP-10 held for at least TWAKE_CYC sampled cycles and then followed by LP-11 gives `wake_ok`. A shorter hold gives `wake_err` instead. Both return to the stop state. A return to LP-00 during the hold restarts the wait.
- R9: In escape mode, LP-10 followed by LP-11 gives one `esc_exit` pulse, drops any partial byte and returns to the stop state.
- R10: Two Marks in a row with no Space between them give one `seq_err` pulse. No further bits are decoded until LP-11 is sampled.
- R11: Any unexpected state in a request sequence, or LP-11 reached in escape mode other than by exit, gives one `seq_err` pulse and waits for LP-11.
- R12: The number of cycles a line state is held (outside wake-up) does not change what is decoded.
- R13: A command other than the two codes is still reported on `cmd_byte`/`cmd_vld`, but the bits that follow produce no data until escape exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_line | input | 2 | Synchronised line levels, bit 1 positive, bit 0 negative |
| hs_start | output | 1 | High-speed entry pulse |
| esc_start | output | 1 | Escape entry pulse |
| bta_seen | output | 1 | Turnaround request pulse |
| ulps_start | output | 1 | Ultra-low-power entry pulse |
| wake_ok | output | 1 | Wake-up completed pulse |
| wake_err | output | 1 | Wake-up Mark too short pulse |
| esc_exit | output | 1 | Escape exit pulse |
| cmd_vld | output | 1 | Entry command valid pulse |
| cmd_byte | output | BYTE_W | Last entry command |
| lpd_vld | output | 1 | Data byte valid pulse |
| lpd_byte | output | BYTE_W | Last data byte |
| seq_err | output | 1 | Sequence error pulse |

## Verification
The bench builds the receiver with an 8-bit symbol width, the default command codes and a wake-up time of 40 cycles instead of a millisecond-scale count. The short wake-up time lets the bench try holds one cycle below the threshold and exactly at it, plus a hold interrupted by a return to Space, all within a short run. Line-state hold lengths are drawn at random from one to three cycles, so the change-driven decoding is exercised against uneven timing. Random data bytes cover both Mark values in every bit position.

// File: rtl/lpesc_pkg.sv
package lpesc_pkg;
   localparam logic [1:0] LN_00 = 2'b00;
   localparam logic [1:0] LN_01 = 2'b01;
   localparam logic [1:0] LN_10 = 2'b10;
   localparam logic [1:0] LN_11 = 2'b11;

   typedef enum logic [3:0] {
      S_WAIT, S_STOP, S_H1, S_HS, S_A1, S_A2, S_E3, S_T3,
      S_CMD, S_LPDT, S_IGN, S_ULPS, S_WAKE
   } lane_st_t;
endpackage

// File: rtl/lpesc_edge.sv
module lpesc_edge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_i,
   output logic       ev_o
);
   logic [1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b11;
      else        prev_q <= line_i;
   end

   assign ev_o = (line_i != prev_q);
endmodule

// File: rtl/lpesc_bitdec.sv
module lpesc_bitdec
   import lpesc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       ev_i,
   input  logic [1:0] line_i,
   output logic       bit_vld_o,
   output logic       bit_val_o,
   output logic       dbl_mark_o,
   output logic       exit_o,
   output logic       bad_o
);
   logic mark_q;
   logic val_q;

   always_comb begin
      bit_vld_o  = 1'b0;
      bit_val_o  = val_q;
      dbl_mark_o = 1'b0;
      exit_o     = 1'b0;
      bad_o      = 1'b0;
      if (en_i && ev_i) begin
         case (line_i)
            LN_00: bit_vld_o = mark_q;
            LN_01, LN_10: dbl_mark_o = mark_q;
            default: begin
               if (mark_q && val_q) exit_o = 1'b1;
               else                 bad_o  = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_q <= 1'b0;
         val_q  <= 1'b0;
      end else if (!en_i) begin
         mark_q <= 1'b0;
         val_q  <= 1'b0;
      end else if (ev_i) begin
         mark_q <= (line_i == LN_01) || (line_i == LN_10);
         val_q  <= (line_i == LN_10);
      end
   end
endmodule

// File: rtl/lpesc_shift.sv
module lpesc_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         bit_vld_i,
   input  logic         bit_i,
   output logic         done_o,
   output logic [W-1:0] byte_o
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt_q;
   logic [W-2:0]  sr_q;
   logic [W-2:0]  sr_nx;

   generate
      if (W == 2) begin : g_narrow
         assign sr_nx = bit_i;
      end else begin : g_wide
         assign sr_nx = {bit_i, sr_q[W-2:1]};
      end
   endgenerate

   assign done_o = bit_vld_i && (cnt_q == LAST);
   assign byte_o = {bit_i, sr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sr_q  <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (bit_vld_i) begin
         sr_q  <= sr_nx;
         cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lpesc_wake.sv
module lpesc_wake #(
   parameter int TWAKE_CYC = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   output logic reached_o
);
   generate
      if (TWAKE_CYC <= 1) begin : g_trivial
         assign reached_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(TWAKE_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(TWAKE_CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (start_i)                cnt_q <= CW'(1);
            else if (run_i && cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
         end

         assign reached_o = (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/lpesc_rx.sv
module lpesc_rx
   import lpesc_pkg::*;
#(
   parameter int                BYTE_W    = 8,
   parameter int                TWAKE_CYC = 50000,
   parameter logic [BYTE_W-1:0] CMD_ULPS  = BYTE_W'(8'h1E),
   parameter logic [BYTE_W-1:0] CMD_LPDT  = BYTE_W'(8'hE1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        lp_line,
   output logic              hs_start,
   output logic              esc_start,
   output logic              bta_seen,
   output logic              ulps_start,
   output logic              wake_ok,
   output logic              wake_err,
   output logic              esc_exit,
   output logic              cmd_vld,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic              lpd_vld,
   output logic [BYTE_W-1:0] lpd_byte,
   output logic              seq_err
);
   initial begin
      assert (BYTE_W >= 2) else $error("BYTE_W must be at least 2");
      assert (TWAKE_CYC >= 1) else $error("TWAKE_CYC must be at least 1");
      assert (CMD_ULPS != CMD_LPDT) else $error("command codes must differ");
   end

   lane_st_t st_q, st_nx;
   logic ev, esc_en;
   logic bit_vld, bit_val, dbl_mark, exit_req, bad_stop;
   logic byte_done;
   logic [BYTE_W-1:0] byte_w;
   logic wake_start, wake_run, wake_reached;

   logic p_hs, p_esc, p_bta, p_ulps, p_wok, p_werr, p_exit, p_cmd, p_dat, p_err;

   assign esc_en     = (st_q == S_CMD) || (st_q == S_LPDT) || (st_q == S_IGN);
   assign wake_start = (st_q == S_ULPS) && ev && (lp_line == LN_10);
   assign wake_run   = (st_q == S_WAKE) && !ev;

   lpesc_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (lp_line),
      .ev_o   (ev)
   );

   lpesc_bitdec u_bitdec (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (esc_en),
      .ev_i       (ev),
      .line_i     (lp_line),
      .bit_vld_o  (bit_vld),
      .bit_val_o  (bit_val),
      .dbl_mark_o (dbl_mark),
      .exit_o     (exit_req),
      .bad_o      (bad_stop)
   );

   lpesc_shift #(.W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (!esc_en),
      .bit_vld_i (bit_vld),
      .bit_i     (bit_val),
      .done_o    (byte_done),
      .byte_o    (byte_w)
   );

   lpesc_wake #(.TWAKE_CYC(TWAKE_CYC)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (wake_start),
      .run_i     (wake_run),
      .reached_o (wake_reached)
   );

   always_comb begin
      st_nx  = st_q;
      p_hs   = 1'b0;
      p_esc  = 1'b0;
      p_bta  = 1'b0;
      p_ulps = 1'b0;
      p_wok  = 1'b0;
      p_werr = 1'b0;
      p_exit = 1'b0;
      p_cmd  = 1'b0;
      p_dat  = 1'b0;
      p_err  = 1'b0;
      case (st_q)
         S_WAIT: if (lp_line == LN_11) st_nx = S_STOP;
         S_STOP: if (ev) begin
            case (lp_line)
               LN_10:   st_nx = S_A1;
               LN_01:   st_nx = S_H1;
               default: p_err = 1'b1;
            endcase
         end
         S_H1: if (ev) begin
            if (lp_line == LN_00) begin
               p_hs  = 1'b1;
               st_nx = S_HS;
            end else p_err = 1'b1;
         end
         S_HS: if (lp_line == LN_11) st_nx = S_STOP;
         S_A1: if (ev) begin
            if (lp_line == LN_00) st_nx = S_A2;
            else                  p_err = 1'b1;
         end
         S_A2: if (ev) begin
            case (lp_line)
               LN_01:   st_nx = S_E3;
               LN_10:   st_nx = S_T3;
               default: p_err = 1'b1;
            endcase
         end
         S_E3: if (ev) begin
            if (lp_line == LN_00) begin
               p_esc = 1'b1;
               st_nx = S_CMD;
            end else p_err = 1'b1;
         end
         S_T3: if (ev) begin
            if (lp_line == LN_00) begin
               p_bta = 1'b1;
               st_nx = S_WAIT;
            end else p_err = 1'b1;
         end
         S_CMD, S_LPDT, S_IGN: begin
            if (exit_req) begin
               p_exit = 1'b1;
               st_nx  = S_STOP;
            end else if (dbl_mark || bad_stop) begin
               p_err = 1'b1;
            end else if (byte_done) begin
               if (st_q == S_CMD) begin
                  p_cmd = 1'b1;
                  if (byte_w == CMD_ULPS) begin
                     p_ulps = 1'b1;
                     st_nx  = S_ULPS;
                  end else if (byte_w == CMD_LPDT) begin
                     st_nx = S_LPDT;
                  end else begin
                     st_nx = S_IGN;
                  end
               end else if (st_q == S_LPDT) begin
                  p_dat = 1'b1;
               end
            end
         end
         S_ULPS: if (ev) begin
            if (lp_line == LN_10) st_nx = S_WAKE;
            else                  p_err = 1'b1;
         end
         S_WAKE: if (ev) begin
            case (lp_line)
               LN_11: begin
                  p_wok  = wake_reached;
                  p_werr = !wake_reached;
                  st_nx  = S_STOP;
               end
               LN_00:   st_nx = S_ULPS;
               default: p_err = 1'b1;
            endcase
         end
         default: st_nx = S_WAIT;
      endcase
      if (p_err) st_nx = S_WAIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_WAIT;
         hs_start   <= 1'b0;
         esc_start  <= 1'b0;
         bta_seen   <= 1'b0;
         ulps_start <= 1'b0;
         wake_ok    <= 1'b0;
         wake_err   <= 1'b0;
         esc_exit   <= 1'b0;
         cmd_vld    <= 1'b0;
         cmd_byte   <= '0;
         lpd_vld    <= 1'b0;
         lpd_byte   <= '0;
         seq_err    <= 1'b0;
      end else begin
         st_q       <= st_nx;
         hs_start   <= p_hs;
         esc_start  <= p_esc;
         bta_seen   <= p_bta;
         ulps_start <= p_ulps;
         wake_ok    <= p_wok;
         wake_err   <= p_werr;
         esc_exit   <= p_exit;
         cmd_vld    <= p_cmd;
         lpd_vld    <= p_dat;
         seq_err    <= p_err;
         if (p_cmd) cmd_byte <= byte_w;
         if (p_dat) lpd_byte <= byte_w;
      end
   end
endmodule

// File: rtl/lpesc_rx_chk.sv
module lpesc_rx_chk #(
   parameter int                BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] CMD_ULPS = BYTE_W'(8'h1E)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        lp_line,
   input logic              hs_start,
   input logic              esc_start,
   input logic              bta_seen,
   input logic              ulps_start,
   input logic              wake_ok,
   input logic              wake_err,
   input logic              esc_exit,
   input logic              cmd_vld,
   input logic [BYTE_W-1:0] cmd_byte,
   input logic              lpd_vld,
   input logic              seq_err
);
   a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hs_start, esc_start, bta_seen, ulps_start, wake_ok, wake_err,
                esc_exit, lpd_vld, seq_err}));

   a_r2_hs_on_space: assert property (@(posedge clk) disable iff (!rst_n)
      hs_start |-> $past(lp_line) == 2'b00);

   a_r3_bta_on_space: assert property (@(posedge clk) disable iff (!rst_n)
      bta_seen |-> $past(lp_line) == 2'b00);

   a_r4_esc_on_space: assert property (@(posedge clk) disable iff (!rst_n)
      esc_start |-> $past(lp_line) == 2'b00);

   a_r5_cmd_on_space: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> $past(lp_line) == 2'b00);

   a_r6_data_on_space: assert property (@(posedge clk) disable iff (!rst_n)
      lpd_vld |-> $past(lp_line) == 2'b00);

   a_r7_ulps_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      ulps_start |-> (cmd_vld && cmd_byte == CMD_ULPS));

   a_r8_wake_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_ok || wake_err) |-> $past(lp_line) == 2'b11);

   a_r9_exit_after_mark1: assert property (@(posedge clk) disable iff (!rst_n)
      esc_exit |-> ($past(lp_line) == 2'b11 && $past(lp_line, 2) == 2'b10));
endmodule

bind lpesc_rx lpesc_rx_chk #(.BYTE_W(BYTE_W), .CMD_ULPS(CMD_ULPS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lp_line    (lp_line),
   .hs_start   (hs_start),
   .esc_start  (esc_start),
   .bta_seen   (bta_seen),
   .ulps_start (ulps_start),
   .wake_ok    (wake_ok),
   .wake_err   (wake_err),
   .esc_exit   (esc_exit),
   .cmd_vld    (cmd_vld),
   .cmd_byte   (cmd_byte),
   .lpd_vld    (lpd_vld),
   .seq_err    (seq_err)
);

// File: tb/tb_lpesc_rx.sv
module tb_lpesc_rx;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] lp_line = 2'b11;
   logic hs_start, esc_start, bta_seen, ulps_start, wake_ok, wake_err;
   logic esc_exit, cmd_vld, lpd_vld, seq_err;
   logic [7:0] cmd_byte, lpd_byte;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lpesc_rx #(.BYTE_W(8), .TWAKE_CYC(TW)) dut (
      .clk(clk), .rst_n(rst_n), .lp_line(lp_line),
      .hs_start(hs_start), .esc_start(esc_start), .bta_seen(bta_seen),
      .ulps_start(ulps_start), .wake_ok(wake_ok), .wake_err(wake_err),
      .esc_exit(esc_exit), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
      .lpd_vld(lpd_vld), .lpd_byte(lpd_byte), .seq_err(seq_err)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   int c_hs = 0, c_esc = 0, c_bta = 0, c_ulps = 0, c_wok = 0, c_werr = 0;
   int c_exit = 0, c_err = 0;
   int e_hs = 0, e_esc = 0, e_bta = 0, e_ulps = 0, e_wok = 0, e_werr = 0;
   int e_exit = 0, e_err = 0;
   logic [7:0] got_d[$], exp_d[$], got_c[$], exp_c[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (hs_start)   c_hs++;
         if (esc_start)  c_esc++;
         if (bta_seen)   c_bta++;
         if (ulps_start) c_ulps++;
         if (wake_ok)    c_wok++;
         if (wake_err)   c_werr++;
         if (esc_exit)   c_exit++;
         if (seq_err)    c_err++;
         if (cmd_vld)    got_c.push_back(cmd_byte);
         if (lpd_vld)    got_d.push_back(lpd_byte);
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic logic [1:0] mark_of(logic b);
      return b ? 2'b10 : 2'b01;
   endfunction

   function automatic int rh();
      return 1 + int'($urandom % 3);
   endfunction

   task automatic put(logic [1:0] v, int h);
      lp_line = v;
      repeat (h) @(negedge clk);
   endtask

   task automatic send_byte(logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         put(mark_of(b[i]), rh());
         put(2'b00, rh());
      end
   endtask

   task automatic esc_entry();
      put(2'b10, rh()); put(2'b00, rh()); put(2'b01, rh()); put(2'b00, rh());
      e_esc++;
   endtask

   task automatic esc_leave();
      put(2'b10, rh()); put(2'b11, 3);
      e_exit++;
   endtask

   task automatic check_all(string req);
      chk({req, " hs_start count"},   c_hs,   e_hs);
      chk({req, " esc_start count"},  c_esc,  e_esc);
      chk({req, " bta_seen count"},   c_bta,  e_bta);
      chk({req, " ulps_start count"}, c_ulps, e_ulps);
      chk({req, " wake_ok count"},    c_wok,  e_wok);
      chk({req, " wake_err count"},   c_werr, e_werr);
      chk({req, " esc_exit count"},   c_exit, e_exit);
      chk({req, " seq_err count"},    c_err,  e_err);
      chk({req, " data byte count"},  got_d.size(), exp_d.size());
      chk({req, " cmd byte count"},   got_c.size(), exp_c.size());
      if (got_d.size() == exp_d.size())
         foreach (exp_d[i]) chk({req, " data byte"}, got_d[i], exp_d[i]);
      if (got_c.size() == exp_c.size())
         foreach (exp_c[i]) chk({req, " cmd byte"}, got_c[i], exp_c[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      // R1: pulses idle in reset
      chk("R1 pulses in reset",
          {hs_start, esc_start, bta_seen, ulps_start, wake_ok, wake_err,
           esc_exit, cmd_vld, lpd_vld, seq_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pulses after reset",
          {hs_start, esc_start, bta_seen, ulps_start, wake_ok, wake_err,
           esc_exit, cmd_vld, lpd_vld, seq_err}, 0);
      put(2'b11, 3);

      // R2: high-speed entry with exact pulse cycle, then lines ignored
      put(2'b01, 2);
      put(2'b00, 1);
      chk("R2 hs_start cycle", hs_start, 1);
      e_hs++;
      put(2'b00, 2);
      put(2'b10, 1); put(2'b00, 1); put(2'b01, 1); put(2'b00, 1);
      put(2'b10, 1); put(2'b00, 2);
      put(2'b11, 3);
      check_all("R2");

      // R3: turnaround, then lines ignored until stop
      put(2'b10, rh()); put(2'b00, rh()); put(2'b10, rh()); put(2'b00, 1);
      chk("R3 bta_seen cycle", bta_seen, 1);
      e_bta++;
      put(2'b00, 1); put(2'b01, 2); put(2'b00, 2);
      put(2'b11, 3);
      check_all("R3");

      // R4 R5 R6 R9: data reception then exit
      esc_entry();
      send_byte(8'hE1); exp_c.push_back(8'hE1);
      for (int k = 0; k < 3; k++) begin
         logic [7:0] b = 8'($urandom);
         send_byte(b); exp_d.push_back(b);
      end
      send_byte(8'h00); exp_d.push_back(8'h00);
      send_byte(8'hFF); exp_d.push_back(8'hFF);
      esc_leave();
      check_all("R6");

      // R7 R8: ultra-low-power, short wake then good wakes
      esc_entry();
      send_byte(8'h1E); exp_c.push_back(8'h1E); e_ulps++;
      put(2'b00, 5);
      put(2'b10, TW - 1); put(2'b11, 3); e_werr++;
      check_all("R8 short");
      esc_entry();
      send_byte(8'h1E); exp_c.push_back(8'h1E); e_ulps++;
      put(2'b00, 4);
      put(2'b10, TW); put(2'b11, 3); e_wok++;
      check_all("R8 exact");
      esc_entry();
      send_byte(8'h1E); exp_c.push_back(8'h1E); e_ulps++;
      put(2'b10, TW - 5); put(2'b00, 3); put(2'b10, TW); put(2'b11, 3); e_wok++;
      check_all("R7");

      // R10: double mark aborts decoding
      esc_entry();
      send_byte(8'hE1); exp_c.push_back(8'hE1);
      send_byte(8'h3C); exp_d.push_back(8'h3C);
      put(2'b01, 2); put(2'b10, 2); e_err++;
      put(2'b00, 1); put(2'b01, 1); put(2'b00, 1); put(2'b10, 1); put(2'b00, 1);
      put(2'b11, 3);
      put(2'b01, 1); put(2'b00, 2); e_hs++;
      put(2'b11, 3);
      check_all("R10");

      // R11: request errors
      put(2'b10, 2); put(2'b11, 3); e_err++;
      put(2'b00, 2); e_err++;
      put(2'b11, 3);
      put(2'b10, 1); put(2'b00, 1); put(2'b11, 3); e_err++;
      put(2'b01, 2); put(2'b10, 2); e_err++;
      put(2'b11, 3);
      esc_entry();
      put(2'b01, 1); put(2'b00, 1); put(2'b11, 3); e_err++;
      check_all("R11");

      // R13: unknown command ignored until exit
      esc_entry();
      send_byte(8'h55); exp_c.push_back(8'h55);
      send_byte(8'hA5);
      send_byte(8'hE1);
      esc_leave();
      check_all("R13");

      // R9: exit with partial byte drops it
      esc_entry();
      send_byte(8'hE1); exp_c.push_back(8'hE1);
      put(2'b10, 1); put(2'b00, 1); put(2'b01, 2); put(2'b00, 1);
      esc_leave();
      check_all("R9");

      // R12: random hold lengths and random payloads
      for (int it = 0; it < 20; it++) begin
         int kind = int'($urandom % 4);
         if (kind == 0) begin
            put(2'b01, rh()); put(2'b00, rh()); e_hs++; put(2'b11, rh());
         end else if (kind == 1) begin
            put(2'b10, rh()); put(2'b00, rh()); put(2'b10, rh()); put(2'b00, rh());
            e_bta++; put(2'b11, rh());
         end else begin
            int n = 1 + int'($urandom % 4);
            esc_entry();
            send_byte(8'hE1); exp_c.push_back(8'hE1);
            for (int k = 0; k < n; k++) begin
               logic [7:0] b = 8'($urandom);
               send_byte(b); exp_d.push_back(b);
            end
            esc_leave();
         end
         put(2'b11, 2);
      end
      check_all("R12");

      finish_run();
   end
endmodule